// File: doc/BRIEF.md
# DRAM Page-Mode Access Controller

The controller turns single read and write requests from a processor-side bus into multiplexed row/column DRAM cycles. It drives an active-low row strobe, two active-low column strobes (high and low byte lane), two active-low write enables (high and low byte lane) and a shared multiplexed address bus. The processor raises a request, holds it with its address and access attributes, and drops it after a one-cycle acknowledge that marks the column phase.

Four static control inputs shape the cycles:
- **Lane signalling.** Either two column strobes pick the bytes, or two write enables do.
- **Row strobe between accesses.** The row strobe is either released or held low.
- **Precharge length.** One or two precharge states are used.
- **Page bursts.** When enabled, a request to the row that is still open skips the row phase entirely. A stored open-row register, qualified by a valid flag, provides the comparison.

Both 8-bit and 16-bit data spaces are handled. In an 8-bit space only the low-lane strobes are used.

Top module: `dram_page_ctrl`

## Requirements
- R1: 16-bit space, lane mode 0 (dual column strobe). Write enables are active-low.
  - `cash_no` is asserted for a word or for a byte at `addr_i[0]`=0 (high lane).
  - `casl_no` is asserted for a word or for a byte at `addr_i[0]`=1 (low lane).
  - On a write only `wel_no` is asserted; `weh_no` stays high.
- R2: 16-bit space, lane mode 1 (dual write enable).
  - Only `casl_no` is asserted.
  - On a write, `weh_no` is asserted for a word or a high-lane byte, and `wel_no` for a word or a low-lane byte.
- R3: 8-bit space (`bus16_i`=0). Only `casl_no` and, on writes, `wel_no` are asserted, whatever the lane mode.
- R4: With `cfg_row_hold_i`=0, `ras_no` is high in the cycle after the acknowledge and stays high while idle.
- R5: With `cfg_row_hold_i`=1, `ras_no` stays low after the acknowledge while idle. Clearing the bit while idle releases `ras_no` within three cycles.
- R6: `cfg_pre2_i` selects one (0) or two (1) precharge states with `ras_no` high. A request that finds a held row it cannot reuse acknowledges 3 (one state) or 4 (two states) edges after acceptance.
- R7: With `cfg_burst_i`=0, every access shows a row phase. `ras_no` falls with the row address on `ma_o`. From an idle controller with the row released, the acknowledge follows in 2 edges.
- R8: With `cfg_burst_i`=1 and a held open row equal to the requested row, no row phase occurs and the acknowledge follows in 1 edge. A different row goes through precharge and a new row phase as in R6.
- R9: `ma_o` carries `addr_i[ADDR_W-1:COL_W]` in the row phase and `addr_i[COL_W-1:0]` in the column phase.
- R10: `ack_o` is a single-cycle pulse, asserted during the column phase only. Latency is counted with the edge that first samples `req_i` high as edge 1.
- R11: After reset all strobes are high, `ack_o` is low and no row counts as open, so the first access is a full cycle. All control bits at 0 give dual column strobe, row released, one precharge state and no bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, held until acknowledged |
| wr_i | input | 1 | 1 = write, 0 = read |
| bus16_i | input | 1 | 1 = 16-bit data space, 0 = 8-bit space |
| byte_i | input | 1 | Byte access within a 16-bit space |
| addr_i | input | ADDR_W | Byte address (row bits above column bits) |
| cfg_dual_we_i | input | 1 | Lane signalling: 0 dual column strobe, 1 dual write enable |
| cfg_row_hold_i | input | 1 | Keep row strobe low between accesses |
| cfg_pre2_i | input | 1 | Two precharge states instead of one |
| cfg_burst_i | input | 1 | Enable same-row page access |
| ack_o | output | 1 | One-cycle acknowledge in the column phase |
| ras_no | output | 1 | Row strobe, active low |
| cash_no | output | 1 | High-lane column strobe, active low |
| casl_no | output | 1 | Low-lane column strobe, active low |
| weh_no | output | 1 | High-lane write enable, active low |
| wel_no | output | 1 | Low-lane write enable, active low |
| ma_o | output | MA_W | Multiplexed row/column address |

## Verification
The hardest situation to reach is a request arriving while a row is still held open. Whether it becomes a one-edge page hit or a three- or four-edge close-and-reopen depends on three control bits and on the row left by the previous access.

The stimulus first sets row hold and performs an access to open a row. It then issues same-row and different-row requests under every combination of burst and precharge length. A reference model of the open row in the bench predicts each latency, and records whether a row phase should appear.

Clearing row hold while a row sits open is also driven, to show the row strobe being released without any request.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRE1 = 3'd1,
    ST_PRE2 = 3'd2,
    ST_ROW  = 3'd3,
    ST_COL  = 3'd4
  } dpc_state_e;

  typedef struct packed {
    logic cas_h;
    logic cas_l;
    logic we_h;
    logic we_l;
  } lane_en_t;
endpackage

// File: rtl/dpc_row_track.sv
module dpc_row_track #(
  parameter int ROW_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             open_i,
  input  logic             close_i,
  input  logic [ROW_W-1:0] load_row_i,
  input  logic [ROW_W-1:0] cmp_row_i,
  output logic             vld_o,
  output logic             hit_o
);
  logic [ROW_W-1:0] row_q;
  logic             vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
      vld_q <= 1'b0;
    end else if (close_i) begin
      vld_q <= 1'b0;
    end else if (open_i) begin
      row_q <= load_row_i;
      vld_q <= 1'b1;
    end
  end

  assign vld_o = vld_q;
  assign hit_o = vld_q && (row_q == cmp_row_i);
endmodule

// File: rtl/dpc_lane_map.sv
module dpc_lane_map
  import dpc_pkg::*;
(
  input  logic     bus16_i,
  input  logic     byte_i,
  input  logic     a0_i,
  input  logic     wr_i,
  input  logic     dual_we_i,
  output lane_en_t en_o
);
  logic hi_sel, lo_sel;

  // addr bit 0 = 0 addresses the high lane
  assign hi_sel = !byte_i || !a0_i;
  assign lo_sel = !byte_i || a0_i;

  always_comb begin
    en_o = '0;
    if (!bus16_i) begin
      en_o.cas_l = 1'b1;
      en_o.we_l  = wr_i;
    end else if (!dual_we_i) begin
      en_o.cas_h = hi_sel;
      en_o.cas_l = lo_sel;
      en_o.we_l  = wr_i;
    end else begin
      en_o.cas_l = 1'b1;
      en_o.we_h  = wr_i && hi_sel;
      en_o.we_l  = wr_i && lo_sel;
    end
  end
endmodule

// File: rtl/dpc_seq.sv
module dpc_seq
  import dpc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       hit_i,
  input  logic       vld_i,
  input  logic       hold_i,
  input  logic       pre2_i,
  input  logic       burst_i,
  output dpc_state_e state_o,
  output logic       accept_o
);
  dpc_state_e state_q, state_d;
  logic       pend_q, pend_d;

  assign accept_o = (state_q == ST_IDLE) && req_i;

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_i) begin
          pend_d = 1'b1;
          if (burst_i && hit_i) state_d = ST_COL;
          else if (vld_i)       state_d = ST_PRE1;
          else                  state_d = ST_ROW;
        end else if (vld_i && !hold_i) begin
          state_d = ST_PRE1;
        end
      end
      ST_PRE1: begin
        if (pre2_i)      state_d = ST_PRE2;
        else if (pend_q) state_d = ST_ROW;
        else             state_d = ST_IDLE;
      end
      ST_PRE2: state_d = pend_q ? ST_ROW : ST_IDLE;
      ST_ROW:  state_d = ST_COL;
      ST_COL: begin
        pend_d  = 1'b0;
        state_d = hold_i ? ST_IDLE : ST_PRE1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl
  import dpc_pkg::*;
#(
  parameter int ROW_W = 8,
  parameter int COL_W = 8,
  localparam int ADDR_W = ROW_W + COL_W,
  localparam int MA_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic              bus16_i,
  input  logic              byte_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cfg_dual_we_i,
  input  logic              cfg_row_hold_i,
  input  logic              cfg_pre2_i,
  input  logic              cfg_burst_i,
  output logic              ack_o,
  output logic              ras_no,
  output logic              cash_no,
  output logic              casl_no,
  output logic              weh_no,
  output logic              wel_no,
  output logic [MA_W-1:0]   ma_o
);
  dpc_state_e        state;
  logic              accept, row_vld, row_hit;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_q, bus16_q, byte_q;
  lane_en_t          lane_en;
  logic              in_col;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wr_q    <= 1'b0;
      bus16_q <= 1'b0;
      byte_q  <= 1'b0;
    end else if (accept) begin
      addr_q  <= addr_i;
      wr_q    <= wr_i;
      bus16_q <= bus16_i;
      byte_q  <= byte_i;
    end
  end

  dpc_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .hit_i    (row_hit),
    .vld_i    (row_vld),
    .hold_i   (cfg_row_hold_i),
    .pre2_i   (cfg_pre2_i),
    .burst_i  (cfg_burst_i),
    .state_o  (state),
    .accept_o (accept)
  );

  dpc_row_track #(.ROW_W(ROW_W)) u_row (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .open_i     (state == ST_ROW),
    .close_i    (state == ST_PRE1),
    .load_row_i (addr_q[ADDR_W-1:COL_W]),
    .cmp_row_i  (addr_i[ADDR_W-1:COL_W]),
    .vld_o      (row_vld),
    .hit_o      (row_hit)
  );

  dpc_lane_map u_lane (
    .bus16_i   (bus16_q),
    .byte_i    (byte_q),
    .a0_i      (addr_q[0]),
    .wr_i      (wr_q),
    .dual_we_i (cfg_dual_we_i),
    .en_o      (lane_en)
  );

  assign in_col  = (state == ST_COL);
  assign ack_o   = in_col;
  assign ras_no  = !((state == ST_ROW) || in_col || ((state == ST_IDLE) && row_vld));
  assign cash_no = !(in_col && lane_en.cas_h);
  assign casl_no = !(in_col && lane_en.cas_l);
  assign weh_no  = !(in_col && lane_en.we_h);
  assign wel_no  = !(in_col && lane_en.we_l);

  always_comb begin
    ma_o = '0;
    if (in_col) ma_o[COL_W-1:0] = addr_q[COL_W-1:0];
    else        ma_o[ROW_W-1:0] = addr_q[ADDR_W-1:COL_W];
  end
endmodule

// File: rtl/dram_page_ctrl_chk.sv
module dram_page_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cfg_row_hold_i,
  input logic cfg_pre2_i,
  input logic ack_o,
  input logic ras_no,
  input logic cash_no,
  input logic casl_no,
  input logic weh_no,
  input logic wel_no,
  input logic bus16_q
);
  // R1 R2: the two lane schemes never mix
  a_r1_no_mixed_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cash_no |-> weh_no);

  // R3: 8-bit space uses low-lane strobes only
  a_r3_low_lane_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus16_q |-> (cash_no && weh_no));

  // R4: row released after an access when hold is off
  a_r4_release_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ack_o) && !$past(cfg_row_hold_i)) |-> ras_no);

  // R5: row kept open after an access when hold is on
  a_r5_hold_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ack_o) && $past(cfg_row_hold_i)) |-> !ras_no);

  // R6: two-state precharge keeps the row strobe high a second cycle
  a_r6_two_state_pre: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ras_no) && cfg_pre2_i) |=> ras_no);

  // R10: single-cycle acknowledge inside an open row with a column strobe
  a_r10_ack_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  a_r10_ack_in_col: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (!ras_no && (!cash_no || !casl_no)));

  // R7: column strobes only while the row is open
  a_r7_cas_needs_ras: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cash_no || !casl_no || !weh_no || !wel_no) |-> !ras_no);
endmodule

bind dram_page_ctrl dram_page_ctrl_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .cfg_row_hold_i (cfg_row_hold_i),
  .cfg_pre2_i     (cfg_pre2_i),
  .ack_o          (ack_o),
  .ras_no         (ras_no),
  .cash_no        (cash_no),
  .casl_no        (casl_no),
  .weh_no         (weh_no),
  .wel_no         (wel_no),
  .bus16_q        (bus16_q)
);

// File: tb/sim_dram_page_ctrl.sv
module sim_dram_page_ctrl;
  localparam int ROW_W = 8;
  localparam int COL_W = 8;
  localparam int AW = ROW_W + COL_W;

  typedef struct packed {
    logic [7:0] lat;
    logic [7:0] lreq;
    logic [7:0] col;
    logic [3:0] stb;
    logic [7:0] sreq;
    logic       row;
    logic [7:0] rowv;
  } exp_t;

  logic clk_i = 0, rst_ni = 0;
  logic req_i = 0, wr_i = 0, bus16_i = 0, byte_i = 0;
  logic [AW-1:0] addr_i = '0;
  logic cfg_dual_we_i = 0, cfg_row_hold_i = 0, cfg_pre2_i = 0, cfg_burst_i = 0;
  logic ack_o, ras_no, cash_no, casl_no, weh_no, wel_no;
  logic [7:0] ma_o;

  int errors = 0, checks = 0;
  exp_t q[$];
  bit   m_vld = 0;
  logic [7:0] m_row = '0;

  always #5 clk_i = ~clk_i;

  dram_page_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W)) u0 (.*);

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_stb(input logic wr, b16, byt, a0, dwe);
    logic ch, cl, wh, wl;
    ch = 0; cl = 0; wh = 0; wl = 0;
    if (!b16) begin cl = 1; wl = wr; end
    else if (!dwe) begin ch = !byt || !a0; cl = !byt || a0; wl = wr; end
    else begin cl = 1; wh = wr && (!byt || !a0); wl = wr && (!byt || a0); end
    return ~{ch, cl, wh, wl};
  endfunction

  // driver: predict, push, run the handshake
  task automatic access(input logic wr, b16, byt, input logic [AW-1:0] a);
    exp_t e;
    logic [7:0] r;
    r = a[AW-1:COL_W];
    e.col  = a[7:0];
    e.stb  = exp_stb(wr, b16, byt, a[0], cfg_dual_we_i);
    e.sreq = !b16 ? 8'd3 : (cfg_dual_we_i ? 8'd2 : 8'd1);
    e.rowv = r;
    if (cfg_burst_i && m_vld && m_row == r) begin
      e.lat = 1; e.lreq = 8; e.row = 0;           // R8 page hit
    end else if (m_vld) begin
      e.lat = cfg_pre2_i ? 8'd4 : 8'd3; e.lreq = 6; e.row = 1;  // R6
    end else begin
      e.lat = 2; e.lreq = 7; e.row = 1;           // R7
    end
    m_vld = cfg_row_hold_i;
    m_row = r;
    q.push_back(e);
    @(negedge clk_i);
    wr_i = wr; bus16_i = b16; byte_i = byt; addr_i = a; req_i = 1;
    do @(negedge clk_i); while (!ack_o);
    req_i = 0;
    repeat (4) @(negedge clk_i);
    if (cfg_row_hold_i) chk("R5 ras held low", ras_no, 0);
    else                chk("R4 ras released", ras_no, 1);
  endtask

  // monitor: pop and compare at each acknowledge
  int   lat_cnt = 0;
  bit   row_seen = 0;
  logic [7:0] row_val = '0;
  logic prev_ras = 1;
  always @(posedge clk_i) begin
    #2;
    if (rst_ni) begin
      if (req_i) lat_cnt++;
      if (prev_ras && !ras_no) begin row_seen = 1; row_val = ma_o; end
      if (ack_o) begin
        exp_t e;
        if (q.size() == 0) begin
          chk("R10 unexpected ack", 1, 0);
        end else begin
          e = q.pop_front();
          chk($sformatf("R%0d latency", e.lreq), lat_cnt, int'(e.lat));
          chk("R9 column address", ma_o, e.col);
          chk($sformatf("R%0d strobes", e.sreq), {cash_no, casl_no, weh_no, wel_no}, e.stb);
          chk("R8 row phase present", row_seen, e.row);
          if (e.row && row_seen) chk("R9 row address", row_val, e.rowv);
        end
        lat_cnt = 0; row_seen = 0;
      end
      prev_ras = ras_no;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL R10 watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    repeat (2) @(negedge clk_i);
    // R11 reset state
    chk("R11 strobes idle", {ras_no, cash_no, casl_no, weh_no, wel_no}, 5'b11111);
    chk("R11 ack low", ack_o, 0);
    // R1 dual column strobe, defaults
    access(0, 1, 0, 16'h1234);
    access(1, 1, 0, 16'h1236);
    access(1, 1, 1, 16'h1237);
    access(1, 1, 1, 16'h1238);
    access(0, 1, 1, 16'h2201);
    // R2 dual write enable
    cfg_dual_we_i = 1;
    access(1, 1, 1, 16'h3010);
    access(1, 1, 1, 16'h3011);
    access(1, 1, 0, 16'h3012);
    access(0, 1, 0, 16'h3014);
    // R3 8-bit space under both lane modes
    access(1, 0, 0, 16'h4001);
    cfg_dual_we_i = 0;
    access(1, 0, 1, 16'h4000);
    access(0, 0, 0, 16'h4003);
    // R5 R6 R7 held row, bursts off
    cfg_row_hold_i = 1;
    access(0, 1, 0, 16'h5000);
    access(0, 1, 0, 16'h5002);
    cfg_pre2_i = 1;
    access(1, 1, 0, 16'h5004);
    // R8 bursts on
    cfg_burst_i = 1;
    access(0, 1, 0, 16'h5010);
    access(1, 1, 1, 16'h50ff);
    access(0, 1, 0, 16'h6000);
    cfg_pre2_i = 0;
    access(0, 1, 0, 16'h7000);
    access(1, 1, 0, 16'h7020);
    // R5 clearing hold while idle releases the row
    @(negedge clk_i);
    cfg_row_hold_i = 0;
    m_vld = 0;
    repeat (3) @(negedge clk_i);
    chk("R5 hold cleared releases ras", ras_no, 1);
    // R4 R8 bursts on but row released: always full cycle
    access(0, 1, 0, 16'h7040);
    access(0, 1, 0, 16'h7042);
    repeat (4) @(negedge clk_i);
    chk("R10 queue drained", q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule